// File: doc/BRIEF.md
# Two-Wire Bus Register Front End

This block sits between a processor bus and a two-wire serial bus engine. Software reaches three registers through a small read/write port: control flags, a status code with a clock prescaler, and a transmit data byte. The block turns control writes into single-cycle command strobes for the engine: start, stop, enable, abort and slave release. It takes completion events and status codes back from the engine, and it raises an interrupt request.

Several control flags interact. The transfer-complete flag is set by the engine and cleared when software writes a one to it. A data write made while that flag is low is refused and recorded as a write collision. A stop request behaves differently in master mode and in slave mode. Clearing the enable bit drops every pending request and aborts the engine at once. The bit-level protocol, line filtering and bit-rate timing belong to the engine and are not part of this block.

Register selects on `cpu_addr`: 0 is control, 1 is status, 2 is data, and 3 reads as zero. Control bit positions: 7 transfer complete (write one to clear), 5 start request, 4 stop request, 3 write collision (read-only), 2 enable, 0 interrupt enable. Bits 6 and 1 are reserved.

Top module: `tw_bus_regs`

## Requirements
- R1: After reset, control reads 0x00, status reads 0xF8 (code 5'b11111, prescaler 0), data reads 0x00, all command strobes and `irq` are low, and `eng_en` and `eng_presc` are zero.
- R2: An `eng_done` pulse sets control bit 7. A control write with bit 7 set clears it. A control write with bit 7 clear leaves it unchanged.
- R3: A data write made while control bit 7 is low sets control bit 3 and leaves the data register unchanged. A data write made while bit 7 is high stores the byte, drives it on `eng_tx_data` and clears bit 3.
- R4: In master mode (`eng_slave_mode` low), a control write with bits 4 and 2 set sets the stop bit and pulses `cmd_stop` for one cycle after the write. Writing zero to bit 4 does not clear the stop bit. The stop bit reads zero in the cycle after an `eng_stop_done` pulse.
- R5: In slave mode, a control write with bit 4 set pulses `cmd_release` and does not pulse `cmd_stop`, and the stop bit stays zero.
- R6: A control write with bits 5 and 2 set sets the start bit and pulses `cmd_start` for one cycle. Engine events do not clear the start bit; only a control write with bit 5 clear does.
- R7: A control write that sets bit 2 while the block is disabled pulses `cmd_enable`. A control write with bit 2 clear while the block is enabled pulses `cmd_abort` and clears the start and stop bits. Such a write raises no start or stop strobe. `eng_en` follows bit 2.
- R8: `irq` is high exactly when control bit 7, control bit 0 and `gie` are all high.
- R9: Status bits 7..3 load from `eng_status` when `eng_status_vld` is high and ignore CPU writes. Status bit 2 reads zero. Status bits 1..0 are a read/write prescaler driven on `eng_presc`.
- R10: Control bits 6 and 1 read zero whatever value is written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_wr | input | 1 | Write strobe for the selected register |
| cpu_addr | input | 2 | Register select |
| cpu_wdata | input | REG_W | Write data |
| cpu_rdata | output | REG_W | Read data for the selected register (combinational) |
| gie | input | 1 | Global interrupt enable |
| eng_slave_mode | input | 1 | Engine is operating as a slave |
| eng_done | input | 1 | Engine transfer-complete event pulse |
| eng_stop_done | input | 1 | Engine reports the STOP has been performed |
| eng_status | input | STAT_W | Status code from the engine |
| eng_status_vld | input | 1 | Loads `eng_status` into the status register |
| cmd_start | output | 1 | Start request strobe |
| cmd_stop | output | 1 | Master STOP request strobe |
| cmd_release | output | 1 | Slave recovery strobe: return to unaddressed slave and float both lines |
| cmd_enable | output | 1 | Enable strobe |
| cmd_abort | output | 1 | Abort strobe on disable |
| eng_en | output | 1 | Enable level for the engine |
| eng_presc | output | PRESC_W | Prescaler setting |
| eng_tx_data | output | REG_W | Data register contents |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with REG_W = 8 and STAT_W = 5, which gives a 2-bit prescaler. At those values the status readback is exactly code, reserved zero and prescaler in one byte, so the reset value 0xF8 and a loaded code followed by a prescaler write can be checked byte-for-byte. These widths also keep the fixed control bit positions inside the register, so every flag interaction is visible through the read port: collision against the complete flag, the stop bit cleared by the engine, release in slave mode, abort on disable, and interrupt gating.

// File: rtl/tw_regs_pkg.sv
package tw_regs_pkg;

    // Control register bit positions (software-visible layout)
    localparam int CTL_DONE  = 7;
    localparam int CTL_START = 5;
    localparam int CTL_STOP  = 4;
    localparam int CTL_WCOL  = 3;
    localparam int CTL_EN    = 2;
    localparam int CTL_IE    = 0;
    localparam int CTL_W     = 8;

    typedef enum logic [1:0] {
        SEL_CTL  = 2'd0,
        SEL_STAT = 2'd1,
        SEL_DATA = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic done;
        logic start;
        logic stop;
        logic en;
        logic ie;
        logic p_start;
        logic p_stop;
        logic p_rel;
        logic p_en;
        logic p_abort;
    } ctl_state_t;

endpackage

// File: rtl/tw_ctl_flags.sv
module tw_ctl_flags
    import tw_regs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_ctl,
    input  logic [CTL_W-1:0] wdata,
    input  logic             slave_mode,
    input  logic             eng_done,
    input  logic             eng_stop_done,
    output logic             done,
    output logic             start,
    output logic             stop,
    output logic             en,
    output logic             ie,
    output logic             p_start,
    output logic             p_stop,
    output logic             p_rel,
    output logic             p_en,
    output logic             p_abort
);

    ctl_state_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.p_start = 1'b0;
        st_d.p_stop  = 1'b0;
        st_d.p_rel   = 1'b0;
        st_d.p_en    = 1'b0;
        st_d.p_abort = 1'b0;

        // engine completion of STOP clears the request
        if (eng_stop_done) begin
            st_d.stop = 1'b0;
        end

        if (wr_ctl) begin
            if (wdata[CTL_DONE]) begin
                st_d.done = 1'b0;
            end
            st_d.ie    = wdata[CTL_IE];
            st_d.en    = wdata[CTL_EN];
            st_d.start = wdata[CTL_START] & wdata[CTL_EN];
            if (wdata[CTL_EN]) begin
                if (wdata[CTL_START]) begin
                    st_d.p_start = 1'b1;
                end
                if (wdata[CTL_STOP] && !slave_mode) begin
                    st_d.stop   = 1'b1;
                    st_d.p_stop = 1'b1;
                end
                if (!st_q.en) begin
                    st_d.p_en = 1'b1;
                end
            end else begin
                st_d.stop = 1'b0;
                if (st_q.en) begin
                    st_d.p_abort = 1'b1;
                end
            end
            if (wdata[CTL_STOP] && slave_mode) begin
                st_d.p_rel = 1'b1;
            end
        end

        // a new completion event wins over a clear in the same cycle
        if (eng_done) begin
            st_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done    = st_q.done;
    assign start   = st_q.start;
    assign stop    = st_q.stop;
    assign en      = st_q.en;
    assign ie      = st_q.ie;
    assign p_start = st_q.p_start;
    assign p_stop  = st_q.p_stop;
    assign p_rel   = st_q.p_rel;
    assign p_en    = st_q.p_en;
    assign p_abort = st_q.p_abort;

endmodule

// File: rtl/tw_stat_reg.sv
module tw_stat_reg #(
    parameter int STAT_W  = 5,
    parameter int PRESC_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_stat,
    input  logic [PRESC_W-1:0] wr_presc,
    input  logic [STAT_W-1:0]  eng_status,
    input  logic               eng_status_vld,
    output logic [STAT_W-1:0]  code,
    output logic [PRESC_W-1:0] presc
);

    typedef struct packed {
        logic [STAT_W-1:0]  code;
        logic [PRESC_W-1:0] presc;
    } stat_state_t;

    stat_state_t sr_d, sr_q;

    always_comb begin
        sr_d = sr_q;
        if (wr_stat) begin
            sr_d.presc = wr_presc;
        end
        if (eng_status_vld) begin
            sr_d.code = eng_status;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q.code  <= '1;
            sr_q.presc <= '0;
        end else begin
            sr_q <= sr_d;
        end
    end

    assign code  = sr_q.code;
    assign presc = sr_q.presc;

endmodule

// File: rtl/tw_data_reg.sv
module tw_data_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_data,
    input  logic [W-1:0] wdata,
    input  logic         done,
    output logic [W-1:0] data,
    output logic         wcol
);

    typedef struct packed {
        logic [W-1:0] data;
        logic         wcol;
    } data_state_t;

    data_state_t dr_d, dr_q;

    always_comb begin
        dr_d = dr_q;
        if (wr_data) begin
            if (done) begin
                dr_d.data = wdata;
                dr_d.wcol = 1'b0;
            end else begin
                dr_d.wcol = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dr_q <= '0;
        end else begin
            dr_q <= dr_d;
        end
    end

    assign data = dr_q.data;
    assign wcol = dr_q.wcol;

endmodule

// File: rtl/tw_bus_regs.sv
module tw_bus_regs
    import tw_regs_pkg::*;
#(
    parameter  int REG_W   = 8,
    parameter  int STAT_W  = 5,
    localparam int PRESC_W = REG_W - STAT_W - 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cpu_wr,
    input  logic [1:0]         cpu_addr,
    input  logic [REG_W-1:0]   cpu_wdata,
    output logic [REG_W-1:0]   cpu_rdata,
    input  logic               gie,
    input  logic               eng_slave_mode,
    input  logic               eng_done,
    input  logic               eng_stop_done,
    input  logic [STAT_W-1:0]  eng_status,
    input  logic               eng_status_vld,
    output logic               cmd_start,
    output logic               cmd_stop,
    output logic               cmd_release,
    output logic               cmd_enable,
    output logic               cmd_abort,
    output logic               eng_en,
    output logic [PRESC_W-1:0] eng_presc,
    output logic [REG_W-1:0]   eng_tx_data,
    output logic               irq
);

    reg_sel_e sel;
    logic wr_ctl, wr_stat, wr_data;
    logic done_w, start_w, stop_w, en_w, ie_w, wcol_w;
    logic [STAT_W-1:0]  stat_code_w;
    logic [PRESC_W-1:0] presc_w;
    logic [REG_W-1:0]   data_w;

    assign sel     = reg_sel_e'(cpu_addr);
    assign wr_ctl  = cpu_wr && (sel == SEL_CTL);
    assign wr_stat = cpu_wr && (sel == SEL_STAT);
    assign wr_data = cpu_wr && (sel == SEL_DATA);

    tw_ctl_flags u_ctl (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_ctl        (wr_ctl),
        .wdata         (cpu_wdata[CTL_W-1:0]),
        .slave_mode    (eng_slave_mode),
        .eng_done      (eng_done),
        .eng_stop_done (eng_stop_done),
        .done          (done_w),
        .start         (start_w),
        .stop          (stop_w),
        .en            (en_w),
        .ie            (ie_w),
        .p_start       (cmd_start),
        .p_stop        (cmd_stop),
        .p_rel         (cmd_release),
        .p_en          (cmd_enable),
        .p_abort       (cmd_abort)
    );

    tw_stat_reg #(
        .STAT_W  (STAT_W),
        .PRESC_W (PRESC_W)
    ) u_stat (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_stat        (wr_stat),
        .wr_presc       (cpu_wdata[PRESC_W-1:0]),
        .eng_status     (eng_status),
        .eng_status_vld (eng_status_vld),
        .code           (stat_code_w),
        .presc          (presc_w)
    );

    tw_data_reg #(
        .W (REG_W)
    ) u_data (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_data (wr_data),
        .wdata   (cpu_wdata),
        .done    (done_w),
        .data    (data_w),
        .wcol    (wcol_w)
    );

    always_comb begin
        cpu_rdata = '0;
        unique case (sel)
            SEL_CTL: begin
                cpu_rdata[CTL_DONE]  = done_w;
                cpu_rdata[CTL_START] = start_w;
                cpu_rdata[CTL_STOP]  = stop_w;
                cpu_rdata[CTL_WCOL]  = wcol_w;
                cpu_rdata[CTL_EN]    = en_w;
                cpu_rdata[CTL_IE]    = ie_w;
            end
            SEL_STAT: cpu_rdata = {stat_code_w, 1'b0, presc_w};
            SEL_DATA: cpu_rdata = data_w;
            default:  cpu_rdata = '0;
        endcase
    end

    assign eng_en      = en_w;
    assign eng_presc   = presc_w;
    assign eng_tx_data = data_w;
    assign irq         = done_w & ie_w & gie;

endmodule

// File: rtl/tw_bus_regs_chk.sv
module tw_bus_regs_chk #(
    parameter int REG_W  = 8,
    parameter int STAT_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_wr,
    input logic [1:0]        cpu_addr,
    input logic [REG_W-1:0]  cpu_wdata,
    input logic [REG_W-1:0]  cpu_rdata,
    input logic              gie,
    input logic              eng_slave_mode,
    input logic              eng_done,
    input logic              eng_stop_done,
    input logic              eng_status_vld,
    input logic              cmd_stop,
    input logic              cmd_release,
    input logic              cmd_abort,
    input logic              irq,
    input logic              done_w,
    input logic              start_w,
    input logic              stop_w,
    input logic              en_w,
    input logic              ie_w,
    input logic              wcol_w,
    input logic [STAT_W-1:0] stat_code_w,
    input logic [REG_W-1:0]  data_w
);

    logic ctl_wr, dat_wr;
    assign ctl_wr = cpu_wr && (cpu_addr == 2'd0);
    assign dat_wr = cpu_wr && (cpu_addr == 2'd2);

    AST_IRQ_GLOBAL_GATE: assert property (@(posedge clk) disable iff (!rst_n) !gie |-> !irq); // R8
    AST_IRQ_LOCAL_GATE:  assert property (@(posedge clk) disable iff (!rst_n) !ie_w |-> !irq); // R8
    AST_DONE_SET:        assert property (@(posedge clk) disable iff (!rst_n) eng_done |=> done_w); // R2
    AST_WCOL_SET:        assert property (@(posedge clk) disable iff (!rst_n) (dat_wr && !done_w) |=> wcol_w); // R3
    AST_WCOL_HOLD:       assert property (@(posedge clk) disable iff (!rst_n) (dat_wr && !done_w) |=> $stable(data_w)); // R3
    AST_WCOL_CLEAR:      assert property (@(posedge clk) disable iff (!rst_n) (dat_wr && done_w) |=> (!wcol_w && data_w == $past(cpu_wdata))); // R3
    AST_STOP_AUTOCLR:    assert property (@(posedge clk) disable iff (!rst_n) (eng_stop_done && !ctl_wr) |=> !stop_w); // R4
    AST_SLAVE_NO_STOP:   assert property (@(posedge clk) disable iff (!rst_n) (ctl_wr && eng_slave_mode) |=> !cmd_stop); // R5
    AST_STOP_REL_EXCL:   assert property (@(posedge clk) disable iff (!rst_n) $onehot0({cmd_stop, cmd_release})); // R5
    AST_START_KEPT:      assert property (@(posedge clk) disable iff (!rst_n) (start_w && !ctl_wr) |=> start_w); // R6
    AST_ABORT_DROPS:     assert property (@(posedge clk) disable iff (!rst_n) cmd_abort |-> (!start_w && !stop_w && !en_w)); // R7
    AST_STAT_CODE_RO:    assert property (@(posedge clk) disable iff (!rst_n) !eng_status_vld |=> $stable(stat_code_w)); // R9
    AST_STAT_RSVD_ZERO:  assert property (@(posedge clk) disable iff (!rst_n) (cpu_addr == 2'd1) |-> !cpu_rdata[2]); // R9
    AST_CTL_RSVD_ZERO:   assert property (@(posedge clk) disable iff (!rst_n) (cpu_addr == 2'd0) |-> (!cpu_rdata[6] && !cpu_rdata[1])); // R10

endmodule

bind tw_bus_regs tw_bus_regs_chk #(
    .REG_W  (REG_W),
    .STAT_W (STAT_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cpu_wr         (cpu_wr),
    .cpu_addr       (cpu_addr),
    .cpu_wdata      (cpu_wdata),
    .cpu_rdata      (cpu_rdata),
    .gie            (gie),
    .eng_slave_mode (eng_slave_mode),
    .eng_done       (eng_done),
    .eng_stop_done  (eng_stop_done),
    .eng_status_vld (eng_status_vld),
    .cmd_stop       (cmd_stop),
    .cmd_release    (cmd_release),
    .cmd_abort      (cmd_abort),
    .irq            (irq),
    .done_w         (done_w),
    .start_w        (start_w),
    .stop_w         (stop_w),
    .en_w           (en_w),
    .ie_w           (ie_w),
    .wcol_w         (wcol_w),
    .stat_code_w    (stat_code_w),
    .data_w         (data_w)
);

// File: tb/sim_tw_bus_regs.sv
`timescale 1ns/1ps
module sim_tw_bus_regs;

    localparam int REG_W   = 8;
    localparam int STAT_W  = 5;
    localparam int PRESC_W = REG_W - STAT_W - 1;

    localparam int SIG_RD   = 0;
    localparam int SIG_CMD  = 1;
    localparam int SIG_IRQ  = 2;
    localparam int SIG_DOUT = 3;
    localparam int SIG_LVL  = 4;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               cpu_wr = 1'b0;
    logic [1:0]         cpu_addr = 2'd0;
    logic [REG_W-1:0]   cpu_wdata = '0;
    logic [REG_W-1:0]   cpu_rdata;
    logic               gie = 1'b1;
    logic               eng_slave_mode = 1'b0;
    logic               eng_done = 1'b0;
    logic               eng_stop_done = 1'b0;
    logic [STAT_W-1:0]  eng_status = '0;
    logic               eng_status_vld = 1'b0;
    logic               cmd_start, cmd_stop, cmd_release, cmd_enable, cmd_abort;
    logic               eng_en;
    logic [PRESC_W-1:0] eng_presc;
    logic [REG_W-1:0]   eng_tx_data;
    logic               irq;

    always #5 clk = ~clk;

    tw_bus_regs #(.REG_W(REG_W), .STAT_W(STAT_W)) u0 (
        .clk            (clk),
        .rst_n          (rst_n),
        .cpu_wr         (cpu_wr),
        .cpu_addr       (cpu_addr),
        .cpu_wdata      (cpu_wdata),
        .cpu_rdata      (cpu_rdata),
        .gie            (gie),
        .eng_slave_mode (eng_slave_mode),
        .eng_done       (eng_done),
        .eng_stop_done  (eng_stop_done),
        .eng_status     (eng_status),
        .eng_status_vld (eng_status_vld),
        .cmd_start      (cmd_start),
        .cmd_stop       (cmd_stop),
        .cmd_release    (cmd_release),
        .cmd_enable     (cmd_enable),
        .cmd_abort      (cmd_abort),
        .eng_en         (eng_en),
        .eng_presc      (eng_presc),
        .eng_tx_data    (eng_tx_data),
        .irq            (irq)
    );

    typedef struct {
        int         cyc;
        int         sig;
        logic [7:0] exp;
        string      req;
    } item_t;

    item_t sb_q[$];
    int    cyc = 0;
    int    n_chk = 0;
    int    n_fail = 0;
    bit    finished = 1'b0;

    function automatic logic [7:0] sample(int sig);
        case (sig)
            SIG_RD:   return cpu_rdata;
            SIG_CMD:  return {3'b000, cmd_start, cmd_stop, cmd_release, cmd_enable, cmd_abort};
            SIG_IRQ:  return {7'b0, irq};
            SIG_DOUT: return eng_tx_data;
            default:  return {5'b0, eng_en, eng_presc};
        endcase
    endfunction

    // monitor: compares queued expectations at the falling edge of their cycle
    always @(negedge clk) begin
        item_t it;
        logic [7:0] act;
        while (sb_q.size() > 0 && sb_q[0].cyc <= cyc) begin
            it  = sb_q.pop_front();
            act = sample(it.sig);
            n_chk++;
            if (it.cyc != cyc || act !== it.exp) begin
                n_fail++;
                $display("FAIL %s: signal %0d actual 0x%02h expected 0x%02h", it.req, it.sig, act, it.exp);
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
        cyc++;
        cpu_wr         = 1'b0;
        eng_done       = 1'b0;
        eng_stop_done  = 1'b0;
        eng_status_vld = 1'b0;
    endtask

    task automatic expect_now(int sig, logic [7:0] exp, string req);
        item_t it;
        it.cyc = cyc;
        it.sig = sig;
        it.exp = exp;
        it.req = req;
        sb_q.push_back(it);
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        cpu_addr  = a;
        cpu_wdata = d;
        cpu_wr    = 1'b1;
        step();
    endtask

    task automatic chk_rd(logic [1:0] a, logic [7:0] exp, string req);
        cpu_addr = a;
        expect_now(SIG_RD, exp, req);
        step();
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;

        // R1 reset state
        expect_now(SIG_CMD, 8'h00, "R1");
        expect_now(SIG_IRQ, 8'h00, "R1");
        expect_now(SIG_LVL, 8'h00, "R1");
        chk_rd(2'd0, 8'h00, "R1");
        chk_rd(2'd1, 8'hF8, "R1");
        chk_rd(2'd2, 8'h00, "R1");

        // R10 reserved control bits
        wr(2'd0, 8'h42);
        chk_rd(2'd0, 8'h00, "R10");

        // R7 enable strobe
        wr(2'd0, 8'h04);
        expect_now(SIG_CMD, 8'h02, "R7");
        expect_now(SIG_LVL, 8'h04, "R7");
        chk_rd(2'd0, 8'h04, "R7");

        // R3 collision while complete flag low
        wr(2'd2, 8'hA5);
        chk_rd(2'd0, 8'h0C, "R3");
        chk_rd(2'd2, 8'h00, "R3");

        // R2 complete flag set, writing zero has no effect
        eng_done = 1'b1;
        step();
        chk_rd(2'd0, 8'h8C, "R2");
        wr(2'd0, 8'h04);
        expect_now(SIG_CMD, 8'h00, "R7");
        chk_rd(2'd0, 8'h8C, "R2");

        // R3 write accepted while flag high clears collision
        wr(2'd2, 8'h5A);
        expect_now(SIG_DOUT, 8'h5A, "R3");
        chk_rd(2'd0, 8'h84, "R3");
        chk_rd(2'd2, 8'h5A, "R3");

        // R8 interrupt gating
        expect_now(SIG_IRQ, 8'h00, "R8");
        wr(2'd0, 8'h05);
        expect_now(SIG_IRQ, 8'h01, "R8");
        step();
        gie = 1'b0;
        expect_now(SIG_IRQ, 8'h00, "R8");
        step();
        gie = 1'b1;
        expect_now(SIG_IRQ, 8'h01, "R8");
        step();
        wr(2'd0, 8'h85);
        expect_now(SIG_IRQ, 8'h00, "R2");
        chk_rd(2'd0, 8'h05, "R2");

        // R6 start is kept against engine events
        wr(2'd0, 8'h25);
        expect_now(SIG_CMD, 8'h10, "R6");
        chk_rd(2'd0, 8'h25, "R6");
        eng_done      = 1'b1;
        eng_stop_done = 1'b1;
        step();
        chk_rd(2'd0, 8'hA5, "R6");
        wr(2'd0, 8'h85);
        chk_rd(2'd0, 8'h05, "R6");

        // R4 master stop and engine auto-clear
        wr(2'd0, 8'h15);
        expect_now(SIG_CMD, 8'h08, "R4");
        chk_rd(2'd0, 8'h15, "R4");
        expect_now(SIG_CMD, 8'h00, "R4");
        wr(2'd0, 8'h05);
        chk_rd(2'd0, 8'h15, "R4");
        eng_stop_done = 1'b1;
        step();
        chk_rd(2'd0, 8'h05, "R4");

        // R5 slave recovery instead of STOP
        eng_slave_mode = 1'b1;
        wr(2'd0, 8'h15);
        expect_now(SIG_CMD, 8'h04, "R5");
        chk_rd(2'd0, 8'h05, "R5");
        eng_slave_mode = 1'b0;

        // R7 abort on disable drops pending requests
        wr(2'd0, 8'h35);
        expect_now(SIG_CMD, 8'h18, "R7");
        chk_rd(2'd0, 8'h35, "R7");
        wr(2'd0, 8'h31);
        expect_now(SIG_CMD, 8'h01, "R7");
        expect_now(SIG_LVL, 8'h00, "R7");
        chk_rd(2'd0, 8'h01, "R7");
        wr(2'd0, 8'h20);
        expect_now(SIG_CMD, 8'h00, "R7");
        chk_rd(2'd0, 8'h00, "R7");

        // R9 status code load, read-only code, prescaler
        eng_status     = 5'h08;
        eng_status_vld = 1'b1;
        step();
        chk_rd(2'd1, 8'h40, "R9");
        wr(2'd1, 8'hFF);
        expect_now(SIG_LVL, 8'h03, "R9");
        chk_rd(2'd1, 8'h43, "R9");

        repeat (3) step();
        if (sb_q.size() != 0) begin
            n_chk++;
            n_fail++;
            $display("FAIL scoreboard: actual %0d pending expected 0", sb_q.size());
        end
        finish_run();
    end

endmodule